// File: doc/BRIEF.md
# Step Pulse Generator with Selectable Output Formats

This block turns a signed rate word into drive signals for a stepper motor. Each enabled clock, the magnitude of the rate is added to an unsigned phase register. A carry out of that register asks for one step, and the sign of the rate gives the direction of that step. Requests are kept as a signed balance until the timing sequencer can issue them. The sequencer holds each step pulse active for a programmed number of clocks and keeps a programmed gap between steps. Around every change of direction it enforces a hold time after the last step and a setup time before the next one.

A two-bit format input sets how a step appears on the two output pins. In step-and-direction format, one pin pulses and the other carries the direction. In up/down format, a step pulses one of two pins, chosen by its direction. In quadrature format, a step walks the pin pair through a full Gray cycle. A signed counter, updated as each step starts, gives the position as feedback. A low enable freezes the phase register and starts no new step. Requests that are already waiting are kept and issued once enable returns.

Top module: `stepgen_core`

## Requirements
- R1: `mode` = 0 gives step on `out_a` and direction on `out_b`, with 1 meaning forward. `mode` = 1 pulses `out_a` for a forward step and `out_b` for a reverse step, never both at once. `mode` = 2 gives quadrature. `mode` = 3 behaves as `mode` = 0.
- R2: In quadrature, with `{out_b,out_a}`, a forward step goes 00→01→11→10→00 and a reverse step goes 00→10→11→01→00. Only one pin changes per clock.
- R3: Each active step level, and each of the three non-idle quadrature codes, lasts exactly max(`step_len`,1) clocks.
- R4: Between the end of one step and the start of the next, the outputs stay idle for at least `step_space` clocks.
- R5: The direction stays unchanged for at least `dir_setup` clocks before the step that follows a reversal.
- R6: A direction change comes at least `dir_hold` clocks after the previous step ends.
- R7: While `enable` is low, no step begins.
- R8: `position` is a signed 32-bit counter. After reset it is 0, and it moves by +1 or −1 as each forward or reverse step starts.
- R9: On each clock with `enable` high, |`rate`| is added modulo 2^32 to a phase register that starts at 0. Each carry out requests one step, with the sign of `rate` giving its direction. While `enable` is low, the phase register holds its value.
- R10: Requests made while a step or timing interval is still running are kept as a signed balance. They are all issued later, so the final position equals the net number of requests.
- R11: After reset, `out_a` is 0, the direction is forward (`out_b` = 1 in `mode` 0) and `position` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows accumulation and new steps |
| rate | input | 32 | Signed rate word added to the phase register each clock |
| mode | input | 2 | Output format select |
| step_len | input | 16 | Active step time in clocks |
| step_space | input | 16 | Minimum idle gap between steps in clocks |
| dir_setup | input | 16 | Direction setup time in clocks |
| dir_hold | input | 16 | Direction hold time in clocks |
| out_a | output | 1 | Step, up, or quadrature bit 0 |
| out_b | output | 1 | Direction, down, or quadrature bit 1 |
| position | output | 32 | Signed step count |

## Verification
The pending balance can change in both directions in the same clock: a carry adds a request while the sequencer launches a step and removes one. The bench provokes this with rate bursts far faster than the step timing allows. A reversed-rate segment follows at once, so the balance also nets across a direction change. The result is judged after a drain period: the final position, and the step count decoded from the pins, must equal a phase-accumulator sum computed in the bench. Pulse widths, gaps, setup and hold are measured on the pins throughout.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

  typedef enum logic [1:0] {
    FMT_STEPDIR = 2'd0,
    FMT_UPDOWN  = 2'd1,
    FMT_QUAD    = 2'd2,
    FMT_SPARE   = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_SPACE = 2'd3
  } seq_e;

  // Gray code for a slot index on the quadrature wheel
  function automatic logic [1:0] gray_of(input logic [1:0] idx);
    return {idx[1], idx[1] ^ idx[0]};
  endfunction

  // Slot index walked forward or backward around the wheel
  function automatic logic [1:0] quad_slot(input logic [1:0] slot, input logic fwd);
    return fwd ? slot : (2'd0 - slot);
  endfunction

endpackage

// File: rtl/stepgen_accum.sv
module stepgen_accum #(
  parameter int PHASE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic signed [PHASE_W-1:0] rate,
  output logic                      step_req,
  output logic                      req_fwd
);

  function automatic logic [PHASE_W-1:0] abs_rate(input logic signed [PHASE_W-1:0] r);
    return r[PHASE_W-1] ? $unsigned(-r) : $unsigned(r);
  endfunction

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, abs_rate(rate)};
  assign step_req = enable & sum[PHASE_W];
  assign req_fwd  = ~rate[PHASE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (enable) acc_q <= sum[PHASE_W-1:0];
  end

  // R9: phase register frozen while disabled
  a_r9_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(acc_q));

endmodule

// File: rtl/stepgen_seq.sv
module stepgen_seq
  import stepgen_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              step_req,
  input  logic              req_fwd,
  input  logic              quad_mode,
  input  logic [TIME_W-1:0] step_len,
  input  logic [TIME_W-1:0] step_space,
  input  logic [TIME_W-1:0] dir_setup,
  input  logic [TIME_W-1:0] dir_hold,
  output seq_e              state_o,
  output logic [1:0]        phase_o,
  output logic              fwd_o,
  output logic              launch_o
);

  localparam logic [TIME_W-1:0]        T_ONE = TIME_W'(1);
  localparam logic [TIME_W-1:0]        T_MAX = '1;
  localparam logic signed [PEND_W-1:0] P_ONE = PEND_W'(1);
  localparam logic signed [PEND_W-1:0] P_MAX = {1'b0, {(PEND_W-1){1'b1}}};
  localparam logic signed [PEND_W-1:0] P_MIN = {1'b1, {(PEND_W-1){1'b0}}};

  function automatic logic [TIME_W-1:0] min_one(input logic [TIME_W-1:0] c);
    return (c == '0) ? T_ONE : c;
  endfunction

  function automatic logic signed [PEND_W-1:0] unit_of(input logic fwd);
    return fwd ? P_ONE : -P_ONE;
  endfunction

  seq_e                      state_q;
  logic [TIME_W-1:0]         tmr_q;
  logic [TIME_W-1:0]         since_end_q;
  logic [1:0]                phase_q;
  logic                      dir_q;
  logic signed [PEND_W-1:0]  pend_q;

  logic want_fwd, pend_nz, hold_met, tmr_last, launch, turn;

  assign want_fwd = ~pend_q[PEND_W-1];
  assign pend_nz  = (pend_q != '0);
  assign hold_met = (since_end_q >= dir_hold);
  assign tmr_last = (tmr_q == T_ONE);
  assign launch   = enable && pend_nz && (want_fwd == dir_q) &&
                    ((state_q == ST_IDLE) || (state_q == ST_SETUP && tmr_last));
  assign turn     = enable && pend_nz && (want_fwd != dir_q) &&
                    (state_q == ST_IDLE) && hold_met;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tmr_q       <= T_ONE;
      since_end_q <= T_MAX;
      phase_q     <= 2'd0;
      dir_q       <= 1'b1;
      pend_q      <= '0;
    end else begin
      pend_q <= pend_q + (step_req ? unit_of(req_fwd) : '0)
                       - (launch ? unit_of(dir_q) : '0);
      if (state_q == ST_PULSE)      since_end_q <= '0;
      else if (since_end_q != T_MAX) since_end_q <= since_end_q + T_ONE;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_PULSE;
            tmr_q   <= min_one(step_len);
            phase_q <= 2'd0;
          end else if (turn) begin
            state_q <= ST_SETUP;
            tmr_q   <= min_one(dir_setup);
            dir_q   <= want_fwd;
          end
        end
        ST_SETUP: begin
          if (tmr_last) begin
            if (launch) begin
              state_q <= ST_PULSE;
              tmr_q   <= min_one(step_len);
              phase_q <= 2'd0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            tmr_q <= tmr_q - T_ONE;
          end
        end
        ST_PULSE: begin
          if (tmr_last) begin
            if (quad_mode && phase_q != 2'd2) begin
              phase_q <= phase_q + 2'd1;
              tmr_q   <= min_one(step_len);
            end else begin
              state_q <= ST_SPACE;
              tmr_q   <= min_one(step_space);
            end
          end else begin
            tmr_q <= tmr_q - T_ONE;
          end
        end
        default: begin
          if (tmr_last) state_q <= ST_IDLE;
          else          tmr_q   <= tmr_q - T_ONE;
        end
      endcase
    end
  end

  assign state_o  = state_q;
  assign phase_o  = phase_q;
  assign fwd_o    = dir_q;
  assign launch_o = launch;

  // R7: nothing starts while disabled
  a_r7_no_launch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !launch);

  // R6: direction moves only after the hold window has elapsed
  a_r6_hold_before_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q != $past(dir_q)) |-> ($past(since_end_q) >= $past(dir_hold)));

  // R5: direction is not changing as a pulse begins
  a_r5_dir_steady_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_PULSE) |-> (dir_q == $past(dir_q)));

  // R10: balance never reaches its limits
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != P_MAX) && (pend_q != P_MIN));

  // R3: quadrature walks at most three active phases
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

endmodule

// File: rtl/stepgen_fmt.sv
module stepgen_fmt
  import stepgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       pulse,
  input  logic [1:0] phase,
  input  logic       fwd,
  output logic       out_a,
  output logic       out_b
);

  logic [1:0] slot;
  logic [1:0] code;

  always_comb begin
    slot = pulse ? (phase + 2'd1) : 2'd0;
    code = gray_of(quad_slot(slot, fwd));
    case (fmt_e'(mode))
      FMT_UPDOWN: begin
        out_a = pulse & fwd;
        out_b = pulse & ~fwd;
      end
      FMT_QUAD: begin
        out_a = code[0];
        out_b = code[1];
      end
      default: begin
        out_a = pulse;
        out_b = fwd;
      end
    endcase
  end

  // R1: up and down never active together
  a_r1_updown_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FMT_UPDOWN) |-> !(out_a && out_b));

  // R2: quadrature pins change one at a time
  a_r2_gray_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FMT_QUAD && $past(mode) == FMT_QUAD) |->
      ($countones({out_b, out_a} ^ $past({out_b, out_a})) <= 1));

endmodule

// File: rtl/stepgen_core.sv
module stepgen_core
  import stepgen_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int TIME_W  = 16,
  parameter int PEND_W  = 16,
  parameter int POS_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic signed [PHASE_W-1:0] rate,
  input  logic [1:0]                mode,
  input  logic [TIME_W-1:0]         step_len,
  input  logic [TIME_W-1:0]         step_space,
  input  logic [TIME_W-1:0]         dir_setup,
  input  logic [TIME_W-1:0]         dir_hold,
  output logic                      out_a,
  output logic                      out_b,
  output logic signed [POS_W-1:0]   position
);

  localparam logic signed [POS_W-1:0] POS_ONE = POS_W'(1);

  logic       step_req, req_fwd, launch, fwd;
  logic [1:0] phase;
  seq_e       state;

  stepgen_accum #(.PHASE_W(PHASE_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate),
    .step_req(step_req), .req_fwd(req_fwd)
  );

  stepgen_seq #(.TIME_W(TIME_W), .PEND_W(PEND_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .step_req(step_req), .req_fwd(req_fwd),
    .quad_mode(mode == FMT_QUAD),
    .step_len(step_len), .step_space(step_space),
    .dir_setup(dir_setup), .dir_hold(dir_hold),
    .state_o(state), .phase_o(phase), .fwd_o(fwd), .launch_o(launch)
  );

  stepgen_fmt fmt_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .pulse(state == ST_PULSE), .phase(phase), .fwd(fwd),
    .out_a(out_a), .out_b(out_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      position <= '0;
    else if (launch) position <= fwd ? (position + POS_ONE) : (position - POS_ONE);
  end

  // R8: one count per launched step, in its direction
  a_r8_pos_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && fwd) |=> (position == $past(position) + POS_ONE));
  a_r8_pos_reverse: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !fwd) |=> (position == $past(position) - POS_ONE));
  a_r8_pos_still: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(position));

endmodule

// File: tb/stepgen_core_tb_top.sv
module stepgen_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DRAIN      = 400;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic signed [31:0] rate = '0;
  logic [1:0]         mode = 2'd0;
  logic [15:0]        step_len = '0, step_space = '0, dir_setup = '0, dir_hold = '0;
  logic               out_a, out_b;
  logic signed [31:0] position;

  stepgen_core dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate), .mode(mode),
    .step_len(step_len), .step_space(step_space), .dir_setup(dir_setup),
    .dir_hold(dir_hold), .out_a(out_a), .out_b(out_b), .position(position)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  longint acc_m = 0, pos_m = 0, mon_steps = 0;
  int md = 0, l_e = 1, s_v = 0, su_v = 0, h_v = 0;
  bit mon_on = 0;
  bit pa, pb, p_now, p_prev;
  logic [1:0] pcode, code;
  int hi_run, lo_run, b_run, run, quarter, d;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qidx(input logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic mon_init();
    pa = out_a; pb = out_b; pcode = {out_b, out_a};
    hi_run = 0; lo_run = 1000; b_run = 1000; run = 1000; quarter = 0;
  endtask

  // Pin-level timing and step decoding
  always @(negedge clk) begin
    if (mon_on) begin
      if (md == 1) begin
        check(!(out_a && out_b), "R1", {out_b, out_a}, 0);
        p_now = out_a | out_b; p_prev = pa | pb;
        if (p_now && !p_prev) begin
          check(lo_run >= s_v, "R4", lo_run, s_v);
          mon_steps += out_a ? 1 : -1;
        end
        if (!p_now && p_prev) check(hi_run == l_e, "R3", hi_run, l_e);
        if (p_now) begin if (!p_prev) hi_run = 0; hi_run++; end
        else begin if (p_prev) lo_run = 0; lo_run++; end
      end else if (md == 2) begin
        code = {out_b, out_a};
        if (code != pcode) begin
          if (pcode != 2'b00) check(run == l_e, "R3", run, l_e);
          else check(run >= s_v, "R4", run, s_v);
          d = (qidx(code) - qidx(pcode)) & 3;
          check(d == 1 || d == 3, "R2", d, 1);
          quarter += (d == 1) ? 1 : -1;
          if (code == 2'b00) begin
            check(quarter == 4 || quarter == -4, "R2", quarter, 4);
            mon_steps += quarter / 4;
            quarter = 0;
          end
          run = 0;
        end
        run++;
      end else begin
        if (out_b != pb) begin
          check(lo_run >= h_v, "R6", lo_run, h_v);
          b_run = 0;
        end
        if (out_a && !pa) begin
          check(b_run >= su_v, "R5", b_run, su_v);
          check(lo_run >= s_v, "R4", lo_run, s_v);
          mon_steps += out_b ? 1 : -1;
        end
        if (!out_a && pa) check(hi_run == l_e, "R3", hi_run, l_e);
        if (out_a) begin if (!pa) hi_run = 0; hi_run++; end
        else begin if (pa) lo_run = 0; lo_run++; end
        b_run++;
      end
      pa = out_a; pb = out_b; pcode = {out_b, out_a};
    end
  end

  // Called at a falling edge; applies rate for exactly ncyc rising edges
  task automatic run_rate(input longint r, input int ncyc);
    longint mag, total;
    rate = 32'(r);
    repeat (ncyc) @(negedge clk);
    rate = '0;
    mag = (r < 0) ? -r : r;
    total = acc_m + mag * ncyc;
    pos_m += ((r < 0) ? -1 : 1) * (total >>> 32);
    acc_m = total & 64'hFFFF_FFFF;
  endtask

  task automatic drain_and_check(input string tag);
    repeat (DRAIN) @(negedge clk);
    check(position == 32'(pos_m), tag, position, pos_m);
    check(mon_steps == pos_m, "R1", mon_steps, pos_m);
  endtask

  task automatic configure(input int m, input int sl, input int sp, input int su, input int hd);
    mon_on = 0;
    md = m; mode = 2'(m);
    step_len = 16'(sl); step_space = 16'(sp); dir_setup = 16'(su); dir_hold = 16'(hd);
    l_e = (sl == 0) ? 1 : sl; s_v = sp; su_v = su; h_v = hd;
    @(negedge clk);
    mon_init();
    mon_on = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint hold_pos;
    bit saw_high;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(out_a == 1'b0, "R11", out_a, 0);
    check(out_b == 1'b1, "R11", out_b, 1);
    check(position == 0, "R11", position, 0);
    enable = 1'b1;

    // Sweep formats and timing settings; R8/R9/R10 judged by final position
    for (int m = 0; m < 3; m++)
      for (int li = 0; li < 2; li++)
        for (int si = 0; si < 2; si++)
          for (int ti = 0; ti < 2; ti++) begin
            configure(m, li ? 2 : 0, si ? 3 : 1, ti ? 4 : 0, ti ? 5 : 1);
            run_rate(64'sd1073741824, 48);
            run_rate(-64'sd268435456, 64);
            drain_and_check("R10");
            run_rate(64'sd1000000007, 30);
            drain_and_check("R8");
          end

    // Spare format code acts as step and direction (R1)
    configure(3, 1, 2, 3, 2);
    run_rate(-64'sd536870912, 40);
    run_rate(64'sd536870912, 40);
    drain_and_check("R1");

    // R7 and R9: disabled, no steps and phase register frozen
    configure(0, 2, 2, 2, 2);
    enable = 1'b0;
    rate = 32'sd1073741824;
    saw_high = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (out_a) saw_high = 1;
    end
    rate = '0;
    check(!saw_high, "R7", saw_high, 0);
    check(position == 32'(pos_m), "R7", position, pos_m);
    enable = 1'b1;
    run_rate(64'sd1073741824, 9);
    drain_and_check("R9");

    // R10: balance kept across a disabled window
    run_rate(64'sd2147483648 - 1, 40);
    enable = 1'b0;
    @(negedge clk);
    hold_pos = position;
    repeat (60) @(negedge clk);
    check(position == 32'(hold_pos), "R7", position, hold_pos);
    check(position != 32'(pos_m), "R10", position, pos_m);
    enable = 1'b1;
    drain_and_check("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule